// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is a small private cache that sits between one core and a shared, arbitrated bus that also reaches memory. It holds a few single-word lines. Each line carries a valid flag, a tag, one data word, a dirty flag and a shared flag. The line index is taken from the low address bits, so each address has exactly one place it can live. Coherence uses write-update:
- A write to a line that another cache may also hold is broadcast on the bus. Every snooping cache whose tag matches copies the new word.
- A write to a line that no other cache holds stays local.
- Memory is written only when a dirty line is evicted.
- A snooped read that hits a dirty line is answered from this cache instead of from memory.

The core side is a valid/ready request port. The core raises `core_valid` with a command, an address and write data, and must hold all of them unchanged until `core_ready` is seen high at a clock edge. The request completes in that cycle, and for a read `core_rdata` carries the word in that same cycle. `core_ready` is the only back-pressure. It stays low while a needed bus transaction is outstanding, and also in any cycle in which the bus is carrying another cache's transaction. The bus side is plain control. A transaction lasts one cycle: the cycle in which `bus_req` and `bus_gnt` are both high. In that cycle the other caches see it on their snoop inputs, and the fabric returns read data and the wired-OR shared indication. Command codes on `bus_cmd` and `snp_cmd` are 0 = read, 1 = write broadcast, 2 = write-back.

Top module: `wu_snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first request to any address gets no `core_ready` until a bus read (command 0) has completed for it.
- R2: A read miss with a clean or invalid victim makes exactly one bus read. It completes two cycles after it is presented, returning the bus data. A following read of the same address completes in its first cycle with no bus transaction.
- R3: A snooped write broadcast (command 1) whose address is held locally replaces the local word. A later local read returns it without a bus transaction.
- R4: Two writes to the same shared address, presented together by two caches, are serialized in grant order. Both caches then return the later-granted value, and memory holds that value once the dirty line is evicted.
- R5: A local write marks the line dirty and never writes memory by itself. Evicting a dirty line issues a write-back (command 2) of the old address and word, followed directly by the read fill. Evicting a clean line issues no write-back.
- R6: A snooped read (command 0) that hits a dirty line raises `snp_supply` with the line's word on `snp_rdata`. That word is returned to the requester in place of the stale memory word.
- R7: A write that hits a line whose shared flag is 0 completes in its first cycle and causes no bus transaction.
- R8: A write that hits a line whose shared flag is 1 causes exactly one write broadcast and completes in that broadcast's grant cycle.
- R9: The shared flag is loaded from `bus_shared_in` on a fill and on a write broadcast. A snooped read or write that hits a line sets that line's shared flag.
- R10: `core_ready` is low in every cycle in which `snp_valid` is high. A hit presented in such a cycle completes one cycle later.
- R11: Once `bus_req` is raised it stays high, with `bus_cmd` and `bus_addr` unchanged, until `bus_gnt` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Request completes this cycle |
| core_write | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Write word |
| core_rdata | output | DATA_W | Read word, valid when a read completes |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Bus granted; the transaction happens this cycle |
| bus_cmd | output | 2 | 0 read, 1 write broadcast, 2 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Word for write broadcast or write-back |
| bus_shared_in | input | 1 | OR of the other caches' snoop hits |
| bus_rdata | input | DATA_W | Read data from a supplying cache or memory |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped write word |
| snp_hit | output | 1 | Snooped address is held here |
| snp_supply | output | 1 | This cache answers the snooped read |
| snp_rdata | output | DATA_W | Word supplied for a snooped read |

## Verification
The bench builds two instances with ADDR_W = 3, DATA_W = 8 and LINES = 2, joined by a fixed-priority grant and an eight-word memory. This gives four tags per index and two caches. With that configuration every address can be touched, every eviction path (clean, dirty, dirty then refilled from a peer) occurs, and two caches can contend for one line. A sweep mixes reads, writes and same-cycle write pairs over all eight addresses. Each result is compared with arithmetically computed expected words. A final flush of both caches then compares memory word by word.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [1:0] {
    CMD_RD = 2'd0,
    CMD_WR = 2'd1,
    CMD_WB = 2'd2
  } bus_cmd_e;
endpackage

// File: rtl/wu_line_array.sv
module wu_line_array #(
  parameter int LINES  = 2,
  parameter int IDX_W  = 1,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_valid,
  input  logic              upd_dirty,
  input  logic              upd_shared,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic [DATA_W-1:0] upd_data,
  output logic [LINES-1:0]  valid_o,
  output logic [LINES-1:0]  dirty_o,
  output logic [LINES-1:0]  shared_o,
  output logic [TAG_W-1:0]  tag_o  [LINES],
  output logic [DATA_W-1:0] data_o [LINES]
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = upd_en && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[g]  <= 1'b0;
        dirty_o[g]  <= 1'b0;
        shared_o[g] <= 1'b0;
        tag_o[g]    <= '0;
        data_o[g]   <= '0;
      end else if (sel) begin
        valid_o[g]  <= upd_valid;
        dirty_o[g]  <= upd_dirty;
        shared_o[g] <= upd_shared;
        tag_o[g]    <= upd_tag;
        data_o[g]   <= upd_data;
      end
    end
  end
endmodule

// File: rtl/wu_lookup.sv
module wu_lookup #(
  parameter int LINES = 2,
  parameter int IDX_W = 1,
  parameter int TAG_W = 7
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic [LINES-1:0] valid_i,
  input  logic [TAG_W-1:0] tag_i [LINES],
  output logic             hit
);
  assign hit = valid_i[idx] && (tag_i[idx] == tag);
endmodule

// File: rtl/wu_ctrl.sv
module wu_ctrl
  import wu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     core_valid,
  input  logic     core_write,
  input  logic     hit,
  input  logic     line_valid,
  input  logic     line_dirty,
  input  logic     line_shared,
  input  logic     snp_busy,
  input  logic     bus_gnt,
  output logic     core_ready,
  output logic     bus_req,
  output bus_cmd_e bus_cmd,
  output logic     ev_local_wr,
  output logic     ev_fill,
  output logic     ev_bcast,
  output logic     ev_wb
);
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL, ST_BCAST} st_e;
  st_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d        = st_q;
    core_ready  = 1'b0;
    bus_req     = 1'b0;
    bus_cmd     = CMD_RD;
    ev_local_wr = 1'b0;
    ev_fill     = 1'b0;
    ev_bcast    = 1'b0;
    ev_wb       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (core_valid && !snp_busy) begin
          if (hit && (!core_write || !line_shared)) begin
            core_ready  = 1'b1;
            ev_local_wr = core_write;
          end else if (hit) begin
            st_d = ST_BCAST;
          end else if (line_valid && line_dirty) begin
            st_d = ST_WB;
          end else begin
            st_d = ST_FILL;
          end
        end
      end
      ST_WB: begin
        bus_req = 1'b1;
        bus_cmd = CMD_WB;
        if (bus_gnt) begin
          ev_wb = 1'b1;
          st_d  = ST_FILL;
        end
      end
      ST_FILL: begin
        bus_req = 1'b1;
        bus_cmd = CMD_RD;
        if (bus_gnt) begin
          ev_fill = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_BCAST: begin
        bus_req = 1'b1;
        bus_cmd = CMD_WR;
        if (bus_gnt) begin
          ev_bcast   = 1'b1;
          core_ready = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wu_snoop_cache.sv
module wu_snoop_cache
  import wu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic              core_write,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_shared_in,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  output logic              snp_hit,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx, s_idx, u_idx;
  logic [TAG_W-1:0]  c_tag, s_tag, u_tag;
  logic [LINES-1:0]  l_valid, l_dirty, l_shared;
  logic [TAG_W-1:0]  l_tag  [LINES];
  logic [DATA_W-1:0] l_data [LINES];
  logic              c_hit, s_hit;
  logic              u_en, u_valid, u_dirty, u_shared;
  logic [DATA_W-1:0] u_data;
  logic              ev_local_wr, ev_fill, ev_bcast, ev_wb;
  bus_cmd_e          cmd_q, snp_cmd_e;

  assign c_idx     = core_addr[IDX_W-1:0];
  assign c_tag     = core_addr[ADDR_W-1:IDX_W];
  assign s_idx     = snp_addr[IDX_W-1:0];
  assign s_tag     = snp_addr[ADDR_W-1:IDX_W];
  assign snp_cmd_e = bus_cmd_e'(snp_cmd);

  wu_line_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .upd_en(u_en), .upd_idx(u_idx), .upd_valid(u_valid), .upd_dirty(u_dirty),
    .upd_shared(u_shared), .upd_tag(u_tag), .upd_data(u_data),
    .valid_o(l_valid), .dirty_o(l_dirty), .shared_o(l_shared),
    .tag_o(l_tag), .data_o(l_data)
  );

  wu_lookup #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_core_lk (
    .idx(c_idx), .tag(c_tag), .valid_i(l_valid), .tag_i(l_tag), .hit(c_hit)
  );

  wu_lookup #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snp_lk (
    .idx(s_idx), .tag(s_tag), .valid_i(l_valid), .tag_i(l_tag), .hit(s_hit)
  );

  wu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_write(core_write), .hit(c_hit),
    .line_valid(l_valid[c_idx]), .line_dirty(l_dirty[c_idx]), .line_shared(l_shared[c_idx]),
    .snp_busy(snp_valid), .bus_gnt(bus_gnt),
    .core_ready(core_ready), .bus_req(bus_req), .bus_cmd(cmd_q),
    .ev_local_wr(ev_local_wr), .ev_fill(ev_fill), .ev_bcast(ev_bcast), .ev_wb(ev_wb)
  );

  // Snoop responses
  assign snp_hit    = snp_valid && s_hit;
  assign snp_supply = snp_hit && (snp_cmd_e == CMD_RD) && l_dirty[s_idx];
  assign snp_rdata  = l_data[s_idx];

  // Core and bus data paths
  assign core_rdata = l_data[c_idx];
  assign bus_cmd    = cmd_q;
  assign bus_addr   = (cmd_q == CMD_WB) ? {l_tag[c_idx], c_idx} : core_addr;
  assign bus_wdata  = (cmd_q == CMD_WB) ? l_data[c_idx] : core_wdata;

  // Single line update port: snoop, own bus completion and local write never coincide
  always_comb begin
    u_en     = 1'b0;
    u_idx    = c_idx;
    u_valid  = l_valid[c_idx];
    u_dirty  = l_dirty[c_idx];
    u_shared = l_shared[c_idx];
    u_tag    = l_tag[c_idx];
    u_data   = l_data[c_idx];
    if (snp_hit && (snp_cmd_e != CMD_WB)) begin
      u_en     = 1'b1;
      u_idx    = s_idx;
      u_valid  = l_valid[s_idx];
      u_tag    = l_tag[s_idx];
      u_shared = 1'b1;
      if (snp_cmd_e == CMD_WR) begin
        u_data  = snp_wdata;
        u_dirty = 1'b0;
      end else begin
        u_data  = l_data[s_idx];
        u_dirty = l_dirty[s_idx];
      end
    end else if (ev_fill) begin
      u_en     = 1'b1;
      u_valid  = 1'b1;
      u_tag    = c_tag;
      u_data   = bus_rdata;
      u_dirty  = 1'b0;
      u_shared = bus_shared_in;
    end else if (ev_bcast) begin
      u_en     = 1'b1;
      u_data   = core_wdata;
      u_dirty  = 1'b1;
      u_shared = bus_shared_in;
    end else if (ev_wb) begin
      u_en     = 1'b1;
      u_valid  = 1'b0;
      u_dirty  = 1'b0;
      u_shared = 1'b0;
    end else if (ev_local_wr) begin
      u_en    = 1'b1;
      u_data  = core_wdata;
      u_dirty = 1'b1;
    end
  end
endmodule

// File: rtl/wu_snoop_cache_sva.sv
module wu_snoop_cache_sva #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_valid,
  input logic              core_ready,
  input logic              core_write,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_hit,
  input logic              snp_supply
);
  a_r10_snoop_stall: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !core_ready);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd2) |=> (bus_req && bus_cmd == 2'd0));

  a_r6_supply_dirty_read: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_hit && snp_cmd == 2'd0));

  a_r7_write_leaves_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_ready && core_write) |=> !bus_req);

  a_r2_accept_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_ready) |-> (!bus_req || bus_gnt));
endmodule

bind wu_snoop_cache wu_snoop_cache_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .core_valid(core_valid), .core_ready(core_ready), .core_write(core_write),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_hit(snp_hit), .snp_supply(snp_supply)
);

// File: tb/wu_snoop_cache_tb.sv
`timescale 1ns/100ps
module wu_snoop_cache_tb;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cv [2];
  logic          cw [2];
  logic [AW-1:0] ca [2];
  logic [DW-1:0] cd [2];
  logic          crdy [2];
  logic [DW-1:0] crd [2];
  logic          breq [2];
  logic          gnt [2];
  logic [1:0]    bcmd [2];
  logic [AW-1:0] baddr [2];
  logic [DW-1:0] bwd [2];
  logic          shit [2];
  logic          ssup [2];
  logic [DW-1:0] srd [2];
  logic [DW-1:0] brd [2];
  logic [DW-1:0] mem [NA];
  logic [DW-1:0] gold [NA];

  int n_chk = 0;
  int n_fail = 0;
  int ntx = 0;

  assign gnt[0] = breq[0];
  assign gnt[1] = breq[1] && !breq[0];
  assign brd[0] = ssup[1] ? srd[1] : mem[baddr[0]];
  assign brd[1] = ssup[0] ? srd[0] : mem[baddr[1]];

  wu_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_valid(cv[0]), .core_ready(crdy[0]), .core_write(cw[0]), .core_addr(ca[0]),
    .core_wdata(cd[0]), .core_rdata(crd[0]),
    .bus_req(breq[0]), .bus_gnt(gnt[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]),
    .bus_wdata(bwd[0]), .bus_shared_in(shit[1]), .bus_rdata(brd[0]),
    .snp_valid(gnt[1]), .snp_cmd(bcmd[1]), .snp_addr(baddr[1]), .snp_wdata(bwd[1]),
    .snp_hit(shit[0]), .snp_supply(ssup[0]), .snp_rdata(srd[0])
  );

  wu_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(2)) u_peer (
    .clk(clk), .rst_n(rst_n),
    .core_valid(cv[1]), .core_ready(crdy[1]), .core_write(cw[1]), .core_addr(ca[1]),
    .core_wdata(cd[1]), .core_rdata(crd[1]),
    .bus_req(breq[1]), .bus_gnt(gnt[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]),
    .bus_wdata(bwd[1]), .bus_shared_in(shit[0]), .bus_rdata(brd[1]),
    .snp_valid(gnt[0]), .snp_cmd(bcmd[0]), .snp_addr(baddr[0]), .snp_wdata(bwd[0]),
    .snp_hit(shit[1]), .snp_supply(ssup[1]), .snp_rdata(srd[1])
  );

  function automatic logic [DW-1:0] init_word(int a);
    return DW'(a * 16 + 5);
  endfunction

  // Memory model: initialised in reset, written only by write-backs
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NA; a++) mem[a] <= init_word(a);
    end else begin
      for (int i = 0; i < 2; i++)
        if (gnt[i] && bcmd[i] == 2'd2) mem[baddr[i]] <= bwd[i];
    end
  end

  always @(negedge clk) if (rst_n && (gnt[0] || gnt[1])) ntx++;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic access(input int c, input bit wr, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q, output int cyc);
    @(negedge clk);
    cv[c] = 1'b1; cw[c] = wr; ca[c] = a[AW-1:0]; cd[c] = d; cyc = 0;
    #1;
    while (!crdy[c]) begin
      @(negedge clk); #1; cyc++;
    end
    q = crd[c];
    @(posedge clk); #1;
    cv[c] = 1'b0;
  endtask

  task automatic rd_chk(input int c, input int a, input string rq);
    logic [DW-1:0] q; int cyc;
    access(c, 1'b0, a, '0, q, cyc);
    check(q == gold[a], rq, q, gold[a]);
  endtask

  task automatic wr_do(input int c, input int a, input logic [DW-1:0] d);
    logic [DW-1:0] q; int cyc;
    access(c, 1'b1, a, d, q, cyc);
    gold[a] = d;
  endtask

  task automatic pair_write(input int a, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    logic [DW-1:0] q0, q1; int k0, k1;
    fork
      access(0, 1'b1, a, d0, q0, k0);
      access(1, 1'b1, a, d1, q1, k1);
    join
    gold[a] = d1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [DW-1:0] q, q2; int cyc, cyc2, t0;
    for (int i = 0; i < 2; i++) begin cv[i] = 0; cw[i] = 0; ca[i] = '0; cd[i] = '0; end
    for (int a = 0; a < NA; a++) gold[a] = init_word(a);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!breq[0] && !breq[1], "R1 no bus request after reset", int'(breq[0]), 0);

    // R1/R2: cold read miss, then hit
    t0 = ntx; access(0, 0, 0, '0, q, cyc);
    check(cyc == 2, "R1 cold read waits for fill", cyc, 2);
    check(ntx - t0 == 1, "R2 one bus read on miss", ntx - t0, 1);
    check(q == init_word(0), "R2 fill data", q, init_word(0));
    t0 = ntx; access(0, 0, 0, '0, q, cyc);
    check(cyc == 0 && ntx == t0, "R2 read hit no bus", cyc, 0);

    // R7/R5: private write stays local
    t0 = ntx; access(0, 1, 0, 8'hA0, q, cyc); gold[0] = 8'hA0;
    check(cyc == 0, "R7 unshared write completes at once", cyc, 0);
    check(ntx == t0, "R7 unshared write no bus", ntx - t0, 0);
    check(mem[0] == init_word(0), "R5 memory untouched by write", mem[0], init_word(0));

    // R6: peer read answered by dirty line
    t0 = ntx; access(1, 0, 0, '0, q, cyc);
    check(q == 8'hA0, "R6 supplied from dirty cache", q, 8'hA0);
    check(mem[0] == init_word(0), "R6 memory still stale", mem[0], init_word(0));

    // R8/R9: now shared, write broadcasts once
    t0 = ntx; access(0, 1, 0, 8'hB1, q, cyc); gold[0] = 8'hB1;
    check(ntx - t0 == 1, "R8 one broadcast for shared write", ntx - t0, 1);
    check(cyc == 1, "R8 completes in grant cycle", cyc, 1);

    // R3: peer copy updated
    t0 = ntx; access(1, 0, 0, '0, q, cyc);
    check(q == 8'hB1 && ntx == t0, "R3 snooped write updates copy", q, 8'hB1);

    // R4: simultaneous writes, cache 0 granted first
    t0 = ntx; pair_write(0, 8'hC2, 8'hD3);
    check(ntx - t0 == 2, "R4 two serialized broadcasts", ntx - t0, 2);
    access(0, 0, 0, '0, q, cyc);
    check(q == 8'hD3, "R4 first cache holds later value", q, 8'hD3);
    access(1, 0, 0, '0, q, cyc);
    check(q == 8'hD3, "R4 second cache holds later value", q, 8'hD3);

    // R5: clean eviction has no write-back
    t0 = ntx; access(0, 0, 2, '0, q, cyc);
    check(ntx - t0 == 1, "R5 clean eviction no write-back", ntx - t0, 1);
    check(q == init_word(2), "R2 fill after clean eviction", q, init_word(2));
    check(mem[0] == init_word(0), "R5 memory untouched", mem[0], init_word(0));

    // R9: shared flag reloaded from bus on broadcast
    t0 = ntx; access(1, 1, 0, 8'hE4, q, cyc);
    check(ntx - t0 == 1, "R9 stale shared still broadcasts", ntx - t0, 1);
    t0 = ntx; access(1, 1, 0, 8'hF5, q, cyc); gold[0] = 8'hF5;
    check(ntx == t0 && cyc == 0, "R9 shared cleared by bus", ntx - t0, 0);

    // R5: dirty eviction
    t0 = ntx; access(1, 0, 4, '0, q, cyc);
    check(ntx - t0 == 2 && cyc == 3, "R5 write-back then fill", cyc, 3);
    check(mem[0] == 8'hF5, "R5 memory updated on eviction", mem[0], 8'hF5);
    check(q == init_word(4), "R5 fill after write-back", q, init_word(4));

    // R10: hit stalled by a snoop cycle
    fork
      access(1, 0, 1, '0, q2, cyc2);
      begin @(negedge clk); access(0, 0, 2, '0, q, cyc); end
    join
    check(cyc == 1, "R10 hit stalled during snoop", cyc, 1);
    check(q == init_word(2), "R10 stalled read data", q, init_word(2));
    check(q2 == init_word(1), "R2 peer miss data", q2, init_word(1));

    // Sweep over all addresses with mixed operations
    for (int i = 0; i < 192; i++) begin
      int c = ((i / 3) + i) % 2;
      int a = (i * 3 + i / 8) % NA;
      if (i % 24 == 23) begin
        rd_chk(0, a, "R3 sweep pre-read");
        rd_chk(1, a, "R3 sweep pre-read");
        pair_write(a, DW'(i * 5 + 1), DW'(i * 5 + 2));
        rd_chk(0, a, "R4 sweep pair");
        rd_chk(1, a, "R4 sweep pair");
      end else if (i % 4 == 1 || i % 4 == 2) begin
        wr_do(c, a, DW'(i * 7 + 3));
      end else begin
        rd_chk(c, a, "R3 sweep read");
      end
    end

    // Flush both caches, then compare memory
    for (int a = 0; a < NA; a++) rd_chk(0, a, "R6 flush read");
    for (int a = 0; a < NA; a++) rd_chk(1, a, "R6 flush read");
    for (int a = 0; a < 2; a++) rd_chk(0, a, "R6 flush read");
    for (int a = 0; a < 2; a++) rd_chk(1, a, "R6 flush read");
    repeat (2) @(negedge clk);
    for (int a = 0; a < NA; a++)
      check(mem[a] == gold[a], "R5 memory after flush", mem[a], gold[a]);

    finish_run();
  end
endmodule